// File: doc/BRIEF.md
# Bidirectional Timer Counter Core

This block is the counting heart of a general-purpose timer. A register of `W` bits (16 by default) moves by one step on every enabled timer tick: up or down, as a direction input selects. It can also be forced to zero by a clear input that acts on a tick. A separate CPU load strobe writes any value into the register in a single cycle. The load always wins over clear and count.

A clock-select field gates the tick. When the field is zero the counter is frozen, although the CPU can still load it and read it. Any nonzero value lets an externally supplied tick pulse through. The prescaler and edge detection that make that pulse live outside this block.

The counter runs between zero and a programmable TOP value. Counting up from TOP wraps to zero, and counting down from zero wraps to TOP. Two combinational flags report when the count is at TOP and when it is at zero. An overflow output pulses for one cycle on each upward wrap, and a sticky copy of it holds until software clears it.

Top module: `tick_counter16`

## Requirements
- R1: While `rstN` is low, and at the first rising edge after it, `count` is 0 and both `ovfPulse` and `ovfFlag` are 0.
- R2: When `loadStb` is 1 at a rising edge, `count` takes `loadVal` at that edge. This holds whatever the values of `clkSel`, `tickIn`, `clearCnt` and `countDown`, and that edge raises no overflow pulse.
- R3: When `clkSel` is 0 and `loadStb` is 0, `count` holds its value, and `tickIn` and `clearCnt` have no effect.
- R4: With `clkSel` nonzero (any of codes 1 to 7), the counter acts only at edges where `tickIn` is 1. At edges where `tickIn` is 0 it holds.
- R5: On an enabled tick with `countDown` = 0 and no clear, `count` becomes `count + 1`. When `count` equals `topVal`, it becomes 0 instead.
- R6: On an enabled tick with `countDown` = 1 and no clear, `count` becomes `count - 1`. When `count` is 0, it becomes `topVal` instead.
- R7: On an enabled tick with `clearCnt` = 1 and no load, `count` becomes 0 whatever the direction, and no overflow pulse is raised.
- R8: `atTop` is 1 exactly when `count` equals `topVal`, and `atBottom` is 1 exactly when `count` is 0. Both follow `count` in the same cycle.
- R9: An upward wrap from `topVal` to 0 drives `ovfPulse` high for exactly the one cycle after that edge. The same edge sets `ovfFlag`. `ovfFlag` stays set until an edge with `ovfClr` = 1 and no new wrap; when a wrap and `ovfClr` coincide, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkSel | input | 3 | Tick source select; 0 stops the counter |
| tickIn | input | 1 | Timer tick enable from the external prescaler |
| countDown | input | 1 | 1 selects decrement, 0 selects increment |
| clearCnt | input | 1 | Clear the count on the next enabled tick |
| loadStb | input | 1 | CPU write strobe, highest priority |
| loadVal | input | W | Value written by the CPU |
| topVal | input | W | Upper limit of the counting range |
| ovfClr | input | 1 | Clears the sticky overflow flag |
| count | output | W | Current counter value |
| atTop | output | 1 | Count equals topVal |
| atBottom | output | 1 | Count equals zero |
| ovfPulse | output | 1 | One-cycle pulse after an upward wrap |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
Every change to `count`, `ovfPulse` and `ovfFlag` appears one rising edge after the inputs that cause it. `atTop` and `atBottom` need no extra cycle beyond `count`: they change as soon as `count` or `topVal` does. The bench therefore drives each input pattern on a falling edge and lets one rising edge pass. It compares every output at the following falling edge, before it drives the next pattern. The expected values come from an arithmetic model of the count that the bench steps at that same rising edge.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

  // Strobes sent from the control decode to the datapath each cycle.
  typedef struct packed {
    logic load;      // CPU write this edge
    logic clear;     // zero the count on this tick
    logic inc;       // step up
    logic dec;       // step down
    logic wrapUp;    // count sits at TOP, increment wraps to zero
    logic wrapDown;  // count sits at zero, decrement wraps to TOP
  } cntStrobe_t;

endpackage

// File: rtl/tcnt_ctrl.sv
module tcnt_ctrl
  import tcnt_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] clkSel,
  input  logic             tickIn,
  input  logic             countDown,
  input  logic             clearCnt,
  input  logic             loadStb,
  input  logic             isTop,
  input  logic             isBottom,
  output cntStrobe_t       strobe
);

  logic sourceOn;
  logic tickEn;
  logic stepOk;

  // Any nonzero select code routes the external tick.
  assign sourceOn = |clkSel;
  assign tickEn   = sourceOn & tickIn;

  // The load has the highest priority and masks every tick action.
  assign stepOk = tickEn & ~loadStb & ~clearCnt;

  always_comb begin
    strobe          = '0;
    strobe.load     = loadStb;
    strobe.clear    = tickEn & ~loadStb & clearCnt;
    strobe.inc      = stepOk & ~countDown;
    strobe.dec      = stepOk & countDown;
    strobe.wrapUp   = isTop;
    strobe.wrapDown = isBottom;
  end

endmodule

// File: rtl/tcnt_datapath.sv
module tcnt_datapath
  import tcnt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  cntStrobe_t   strobe,
  input  logic [W-1:0] loadVal,
  input  logic [W-1:0] topVal,
  input  logic         ovfClr,
  output logic [W-1:0] count,
  output logic         isTop,
  output logic         isBottom,
  output logic         ovfPulse,
  output logic         ovfFlag
);

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] countQ;
  logic [W-1:0] countD;
  logic [W-1:0] upVal;
  logic [W-1:0] downVal;
  logic         wrapNow;

  assign isTop    = (countQ == topVal);
  assign isBottom = (countQ == ZERO);

  assign upVal   = strobe.wrapUp   ? ZERO   : countQ + ONE;
  assign downVal = strobe.wrapDown ? topVal : countQ - ONE;
  assign wrapNow = strobe.inc & strobe.wrapUp;

  always_comb begin
    countD = countQ;
    if (strobe.load)       countD = loadVal;
    else if (strobe.clear) countD = ZERO;
    else if (strobe.inc)   countD = upVal;
    else if (strobe.dec)   countD = downVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ   <= ZERO;
      ovfPulse <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      countQ   <= countD;
      ovfPulse <= wrapNow;
      ovfFlag  <= wrapNow | (ovfFlag & ~ovfClr);
    end
  end

  assign count = countQ;

endmodule

// File: rtl/tick_counter16.sv
module tick_counter16
  import tcnt_pkg::*;
#(
  parameter int W     = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             tickIn,
  input  logic             countDown,
  input  logic             clearCnt,
  input  logic             loadStb,
  input  logic [W-1:0]     loadVal,
  input  logic [W-1:0]     topVal,
  input  logic             ovfClr,
  output logic [W-1:0]     count,
  output logic             atTop,
  output logic             atBottom,
  output logic             ovfPulse,
  output logic             ovfFlag
);

  cntStrobe_t strobe;
  logic       isTop;
  logic       isBottom;

  tcnt_ctrl #(.SEL_W(SEL_W)) i_ctrl (
    .clkSel    (clkSel),
    .tickIn    (tickIn),
    .countDown (countDown),
    .clearCnt  (clearCnt),
    .loadStb   (loadStb),
    .isTop     (isTop),
    .isBottom  (isBottom),
    .strobe    (strobe)
  );

  tcnt_datapath #(.W(W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadVal  (loadVal),
    .topVal   (topVal),
    .ovfClr   (ovfClr),
    .count    (count),
    .isTop    (isTop),
    .isBottom (isBottom),
    .ovfPulse (ovfPulse),
    .ovfFlag  (ovfFlag)
  );

  assign atTop    = isTop;
  assign atBottom = isBottom;

endmodule

// File: rtl/tcnt_checker.sv
module tcnt_checker #(
  parameter int W     = 16,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [SEL_W-1:0] clkSel,
  input logic             tickIn,
  input logic             countDown,
  input logic             clearCnt,
  input logic             loadStb,
  input logic [W-1:0]     loadVal,
  input logic [W-1:0]     topVal,
  input logic             ovfClr,
  input logic [W-1:0]     count,
  input logic             ovfPulse,
  input logic             ovfFlag
);

  logic live;
  assign live = (clkSel != '0) && tickIn;

  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> (count == $past(loadVal)) && !ovfPulse);

  // R3
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && clkSel == '0) |=> $stable(count));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && !tickIn) |=> $stable(count));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && live && clearCnt) |=> (count == '0) && !ovfPulse);

  // R5
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && live && !clearCnt && !countDown && count == topVal)
      |=> (count == '0) && ovfPulse && ovfFlag);

  // R6
  down_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadStb && live && !clearCnt && countDown && count == '0)
      |=> count == $past(topVal));

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !ovfPulse || (count == '0));

endmodule

bind tick_counter16 tcnt_checker #(.W(W), .SEL_W(SEL_W)) i_tcnt_checker (
  .clk       (clk),
  .rstN      (rstN),
  .clkSel    (clkSel),
  .tickIn    (tickIn),
  .countDown (countDown),
  .clearCnt  (clearCnt),
  .loadStb   (loadStb),
  .loadVal   (loadVal),
  .topVal    (topVal),
  .ovfClr    (ovfClr),
  .count     (count),
  .ovfPulse  (ovfPulse),
  .ovfFlag   (ovfFlag)
);

// File: tb/test_tick_counter16.sv
module test_tick_counter16;

  localparam int PERIOD = 10;
  localparam int W      = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   clkSel = '0;
  logic         tickIn = 1'b0;
  logic         countDown = 1'b0;
  logic         clearCnt = 1'b0;
  logic         loadStb = 1'b0;
  logic [W-1:0] loadVal = '0;
  logic [W-1:0] topVal = 16'd5;
  logic         ovfClr = 1'b0;
  logic [W-1:0] count;
  logic         atTop, atBottom, ovfPulse, ovfFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [W-1:0] expCnt = '0;
  logic         expPulse = 1'b0;
  logic         expFlag = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  tick_counter16 i_tick_counter16 (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .tickIn(tickIn),
    .countDown(countDown), .clearCnt(clearCnt), .loadStb(loadStb),
    .loadVal(loadVal), .topVal(topVal), .ovfClr(ovfClr), .count(count),
    .atTop(atTop), .atBottom(atBottom), .ovfPulse(ovfPulse), .ovfFlag(ovfFlag)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    cmp(tag, "count", count, expCnt);
    cmp("R8", "atTop", {15'd0, atTop}, {15'd0, expCnt == topVal});
    cmp("R8", "atBottom", {15'd0, atBottom}, {15'd0, expCnt == 16'd0});
    cmp("R9", "ovfPulse", {15'd0, ovfPulse}, {15'd0, expPulse});
    cmp("R9", "ovfFlag", {15'd0, ovfFlag}, {15'd0, expFlag});
  endtask

  // Called at a falling edge: drive, cross one rising edge, check.
  task automatic step(input logic [2:0] s, input logic t, input logic d,
                      input logic cl, input logic ld, input logic oc,
                      input logic [W-1:0] lv);
    string tag;
    logic en;
    logic wrap;
    clkSel = s; tickIn = t; countDown = d; clearCnt = cl;
    loadStb = ld; ovfClr = oc; loadVal = lv;
    en   = (s != 3'd0) && t;
    wrap = !ld && en && !cl && !d && (expCnt == topVal);
    if (ld)       tag = "R2";
    else if (s == 3'd0) tag = "R3";
    else if (!t)  tag = "R4";
    else if (cl)  tag = "R7";
    else if (d)   tag = "R6";
    else          tag = "R5";
    @(posedge clk);
    if (ld) expCnt = lv;
    else if (en) begin
      if (cl)      expCnt = 16'd0;
      else if (!d) expCnt = (expCnt == topVal) ? 16'd0 : expCnt + 16'd1;
      else         expCnt = (expCnt == 16'd0) ? topVal : expCnt - 16'd1;
    end
    expFlag  = wrap | (expFlag & ~oc);
    expPulse = wrap;
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // Sweep of all control combinations from three start values.
    topVal = 16'd5;
    for (int st = 0; st < 3; st++) begin
      for (int c = 0; c < 256; c++) begin
        logic [W-1:0] startV;
        logic [7:0] cb;
        cb = c[7:0];
        startV = (st == 0) ? 16'd0 : (st == 1) ? topVal : 16'd2;
        step(3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, startV);
        step(cb[2:0], cb[3], cb[4], cb[5], cb[6], cb[7], 16'hA5C3);
      end
    end

    // R5: long upward run through several wraps; R9 flag stays sticky.
    step(3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'd0);
    for (int i = 0; i < 20; i++) step(3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0);
    // R9: clear the flag with no wrap pending.
    step(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd0);

    // R6: long downward run through several wraps.
    for (int i = 0; i < 20; i++) step(3'd6, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0);

    // R4: ticks alternate on and off.
    for (int i = 0; i < 16; i++) step(3'd1, i[0], 1'b0, 1'b0, 1'b0, 1'b0, 16'd0);

    // R5: TOP of zero wraps on every tick.
    topVal = 16'd0;
    step(3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'd0);
    for (int i = 0; i < 4; i++) step(3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0);
    // R6: down from zero with TOP zero stays at zero.
    step(3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'd0);

    // R5: full-range TOP wraps through the all-ones value.
    topVal = 16'hFFFF;
    step(3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFD);
    for (int i = 0; i < 4; i++) step(3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0);
    for (int i = 0; i < 4; i++) step(3'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0);

    // R9: wrap and flag clear on the same edge keep the flag set.
    topVal = 16'd2;
    step(3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'd2);
    step(3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'd0);
    step(3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0);

    finishRun();
  end

endmodule